// File: doc/BRIEF.md
# Two-Wire Compelled-Handshake Receiver with Block Framing

This block receives on a two-wire open-drain link where every bit is handshaken both ways. Both wires idle high. The sender pulls exactly one wire low, and the choice of wire carries the bit value. The receiver answers by pulling the other wire low. It keeps that acknowledge asserted until the sender lets its wire go, and then releases it. The link is idle again only when both wires read high.

Received bits are packed most-significant first into bytes, and the bytes are framed into blocks. The first byte of a block is a header. It carries a write flag and the block length in bytes, counting the header itself. The next two bytes form a 16-bit address, and the remaining bytes are payload. The receiver is online while a block is open. It drops offline by itself once the stated number of bytes has arrived.

A break ends a block early. A break is both wires low together, or low within one synchronized sample of each other. After a break, the next byte is taken as the continuation of the interrupted block rather than as a new header. Every completed byte is presented for one cycle with a header/payload tag and its position in the block.

Top module: `cdl_rx_top`

## Requirements
- R1: When the one-line (`line_one_i`) alone goes low from idle, the receiver takes bit value 1 and acknowledges on `pull_zero_o`. It never pulls the one-line for that bit.
- R2: When the zero-line (`line_zero_i`) alone goes low from idle, the receiver takes bit value 0 and acknowledges on `pull_one_o`. It never pulls the zero-line for that bit.
- R3: The acknowledge stays asserted for as long as the sender holds its data wire low. It is removed within 8 cycles after the sender releases that wire. The two pull outputs are never asserted together.
- R4: Bits are assembled most-significant first. Every eighth accepted bit produces exactly one single-cycle `byte_valid_o` pulse, with the assembled value on `byte_data_o`.
- R5: The first byte of a block is reported with `byte_is_hdr_o`=1 and `byte_idx_o`=0. Its bit 7 sets `wr_flag_o`, and its bits 6:0 set `blk_size_o`. For example, 139 gives write=1 and size=11, and 0x05 gives write=0 and size=5.
- R6: Positions 1 and 2 are tagged as header. `addr_o` becomes {byte at position 1, byte at position 2}, and the header byte clears it to zero. Positions 3 and above are tagged as payload, and indices count up by one per byte.
- R7: `online_o` rises after a header whose size is above 1. It falls right after the byte at position size−1. The byte after that is treated as a new header.
- R8: A break (both wires low in the same sample or in adjacent samples) is never acknowledged, and it discards any partly assembled byte. If a block is open, `online_o` falls. The next byte is then a payload continuation whose index follows the last one received, and `online_o` rises again.
- R9: A break while no block is open and a header is expected has no effect on framing: the next byte is still a header at position 0.
- R10: After reset, neither pull output is asserted, `online_o` is 0, no byte strobe is given, and the first byte is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_one_i | input | 1 | Level of the wire whose fall signals bit 1 (1 = high) |
| line_zero_i | input | 1 | Level of the wire whose fall signals bit 0 (1 = high) |
| pull_one_o | output | 1 | 1 = drive the one-line low (acknowledge of a 0 bit) |
| pull_zero_o | output | 1 | 1 = drive the zero-line low (acknowledge of a 1 bit) |
| byte_valid_o | output | 1 | Single-cycle strobe for a completed byte |
| byte_data_o | output | 8 | Completed byte value |
| byte_is_hdr_o | output | 1 | Byte lies in the three header positions |
| byte_idx_o | output | 7 | Position of the byte within its block |
| wr_flag_o | output | 1 | Write flag from the last header |
| blk_size_o | output | 7 | Block length from the last header |
| addr_o | output | 16 | Address assembled from header positions 1 and 2 |
| online_o | output | 1 | A block is open and being received |

## Verification
The assertions assume the sender follows the protocol. It starts a bit only from a fully idle link, it pulls a single wire per bit, it holds that wire until it sees the acknowledge, and it does not let go of a break until both wires are driven low. The bench sender waits for both wires high before every symbol, and it releases its wire only after the acknowledge has been seen and held for several cycles. Breaks are driven both simultaneously and with a one-cycle skew, and always held longer than the synchronizer depth, so the receiver's both-low window is met.

// File: rtl/cdl_rx_pkg.sv
package cdl_rx_pkg;
  typedef enum logic [2:0] {
    HS_IDLE  = 3'd0,
    HS_PEND  = 3'd1,
    HS_ACK   = 3'd2,
    HS_DRAIN = 3'd3,
    HS_BREAK = 3'd4
  } hs_state_e;
endpackage

// File: rtl/cdl_line_sync.sv
module cdl_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cdl_hs_fsm.sv
module cdl_hs_fsm
  import cdl_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_one,
  input  logic s_zero,
  output logic pull_one,
  output logic pull_zero,
  output logic bit_stb,
  output logic bit_val,
  output logic brk_stb
);
  hs_state_e state, nxt;
  logic bit_q, bit_nxt;
  logic both_low, both_high, data_high;

  assign both_low  = !s_one && !s_zero;
  assign both_high = s_one && s_zero;
  assign data_high = bit_q ? s_one : s_zero;

  always_comb begin
    nxt     = state;
    bit_nxt = bit_q;
    unique case (state)
      HS_IDLE: begin
        if (both_low) nxt = HS_BREAK;
        else if (!s_one) begin nxt = HS_PEND; bit_nxt = 1'b1; end
        else if (!s_zero) begin nxt = HS_PEND; bit_nxt = 1'b0; end
      end
      HS_PEND:  nxt = both_low ? HS_BREAK : HS_ACK;
      HS_ACK:   if (data_high) nxt = HS_DRAIN;
      HS_DRAIN: if (both_high) nxt = HS_IDLE;
      HS_BREAK: if (both_high) nxt = HS_IDLE;
      default:  nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_IDLE;
      bit_q <= 1'b0;
    end else begin
      state <= nxt;
      bit_q <= bit_nxt;
    end
  end

  assign bit_stb   = (state == HS_PEND) && (nxt == HS_ACK);
  assign bit_val   = bit_q;
  assign brk_stb   = (state != HS_BREAK) && (nxt == HS_BREAK);
  assign pull_zero = (state == HS_ACK) && bit_q;
  assign pull_one  = (state == HS_ACK) && !bit_q;

  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_one && pull_zero)); // R3
  AST_ACK_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_zero && !s_one) |=> pull_zero); // R3
  AST_ACK_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_one && !s_zero) |=> pull_one); // R3
  AST_ACK_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_zero) |-> $past(bit_stb && bit_val)); // R1
  AST_ACK_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_one) |-> $past(bit_stb && !bit_val)); // R2
  AST_BRK_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    brk_stb |=> (!pull_one && !pull_zero)); // R8
endmodule

// File: rtl/cdl_byte_asm.sv
module cdl_byte_asm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              brk_stb,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shifted;

  assign shifted = {sh[BYTE_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (brk_stb) begin
        cnt <= '0;
      end else if (bit_stb) begin
        sh <= shifted;
        if (cnt == LAST) begin
          cnt       <= '0;
          byte_vld  <= 1'b1;
          byte_data <= shifted;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_BYTE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(bit_stb)); // R4
  AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R4
endmodule

// File: rtl/cdl_frame_trk.sv
module cdl_frame_trk #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = BYTE_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_vld,
  input  logic [BYTE_W-1:0]   byte_data,
  input  logic                brk_stb,
  output logic                out_vld,
  output logic [BYTE_W-1:0]   out_data,
  output logic                out_hdr,
  output logic [IDX_W-1:0]    out_idx,
  output logic                wr_flag,
  output logic [IDX_W-1:0]    blk_size,
  output logic [2*BYTE_W-1:0] addr,
  output logic                online
);
  localparam int ADDR_W    = 2 * BYTE_W;
  localparam int HDR_BYTES = 3;

  function automatic logic hdr_write(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic [IDX_W-1:0] hdr_size(input logic [BYTE_W-1:0] b);
    return b[IDX_W-1:0];
  endfunction

  function automatic logic in_header(input logic [IDX_W-1:0] idx);
    return idx < IDX_W'(HDR_BYTES);
  endfunction

  function automatic logic block_done(input logic [IDX_W:0] next_cnt,
                                      input logic [IDX_W-1:0] size);
    return next_cnt >= {1'b0, size};
  endfunction

  logic             expect_hdr;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] cur_idx, cur_size;
  logic [IDX_W:0]   nxt_cnt;
  logic             done;

  assign cur_idx  = expect_hdr ? '0 : cnt;
  assign cur_size = expect_hdr ? hdr_size(byte_data) : blk_size;
  assign nxt_cnt  = {1'b0, cur_idx} + 1'b1;
  assign done     = block_done(nxt_cnt, cur_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_hdr <= 1'b1;
      cnt        <= '0;
      online     <= 1'b0;
      out_vld    <= 1'b0;
      out_data   <= '0;
      out_hdr    <= 1'b0;
      out_idx    <= '0;
      wr_flag    <= 1'b0;
      blk_size   <= '0;
      addr       <= '0;
    end else begin
      out_vld <= 1'b0;
      if (byte_vld) begin
        out_vld  <= 1'b1;
        out_data <= byte_data;
        out_hdr  <= in_header(cur_idx);
        out_idx  <= cur_idx;
        if (expect_hdr) begin
          wr_flag  <= hdr_write(byte_data);
          blk_size <= hdr_size(byte_data);
          addr     <= '0;
        end else if (cur_idx == IDX_W'(1)) begin
          addr[ADDR_W-1 -: BYTE_W] <= byte_data;
        end else if (cur_idx == IDX_W'(2)) begin
          addr[BYTE_W-1:0] <= byte_data;
        end
        if (done) begin
          online     <= 1'b0;
          expect_hdr <= 1'b1;
          cnt        <= '0;
        end else begin
          online     <= 1'b1;
          expect_hdr <= 1'b0;
          cnt        <= nxt_cnt[IDX_W-1:0];
        end
      end else if (brk_stb && online) begin
        online <= 1'b0;
      end
    end
  end

  AST_ONLINE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && expect_hdr && (hdr_size(byte_data) > IDX_W'(1))) |=> online); // R7
  AST_OFFLINE_ON_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_stb && online && !byte_vld) |=> !online); // R8
  AST_PAYLOAD_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_hdr) |-> (out_idx < blk_size)); // R6
  AST_BRK_KEEPS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_stb && expect_hdr && !byte_vld) |=> expect_hdr); // R9
endmodule

// File: rtl/cdl_rx_top.sv
module cdl_rx_top #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_one_i,
  input  logic                line_zero_i,
  output logic                pull_one_o,
  output logic                pull_zero_o,
  output logic                byte_valid_o,
  output logic [BYTE_W-1:0]   byte_data_o,
  output logic                byte_is_hdr_o,
  output logic [BYTE_W-2:0]   byte_idx_o,
  output logic                wr_flag_o,
  output logic [BYTE_W-2:0]   blk_size_o,
  output logic [2*BYTE_W-1:0] addr_o,
  output logic                online_o
);
  localparam int IDX_W = BYTE_W - 1;

  logic [1:0]        lines_sync;
  logic              s_one, s_zero;
  logic              bit_stb, bit_val, brk_stb;
  logic              asm_vld;
  logic [BYTE_W-1:0] asm_data;

  cdl_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({line_one_i, line_zero_i}),
    .q (lines_sync)
  );
  assign s_one  = lines_sync[1];
  assign s_zero = lines_sync[0];

  cdl_hs_fsm u_hs (
    .clk (clk),
    .rst_n (rst_n),
    .s_one (s_one),
    .s_zero (s_zero),
    .pull_one (pull_one_o),
    .pull_zero (pull_zero_o),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .brk_stb (brk_stb)
  );

  cdl_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk (clk),
    .rst_n (rst_n),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .brk_stb (brk_stb),
    .byte_vld (asm_vld),
    .byte_data (asm_data)
  );

  cdl_frame_trk #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_frame (
    .clk (clk),
    .rst_n (rst_n),
    .byte_vld (asm_vld),
    .byte_data (asm_data),
    .brk_stb (brk_stb),
    .out_vld (byte_valid_o),
    .out_data (byte_data_o),
    .out_hdr (byte_is_hdr_o),
    .out_idx (byte_idx_o),
    .wr_flag (wr_flag_o),
    .blk_size (blk_size_o),
    .addr (addr_o),
    .online (online_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pull_one_o && !pull_zero_o && !online_o)); // R10
endmodule

// File: tb/cdl_rx_top_tb.sv
module cdl_rx_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_one = 1'b0;
  logic tb_zero = 1'b0;
  logic line_one, line_zero;
  logic pull_one_o, pull_zero_o, byte_valid_o, byte_is_hdr_o;
  logic wr_flag_o, online_o;
  logic [7:0]  byte_data_o;
  logic [6:0]  byte_idx_o, blk_size_o;
  logic [15:0] addr_o;

  typedef struct packed {
    logic [7:0] d;
    logic       h;
    logic [6:0] i;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;

  always #4 clk = ~clk;

  assign line_one  = ~(tb_one | pull_one_o);
  assign line_zero = ~(tb_zero | pull_zero_o);

  cdl_rx_top u_dut (
    .clk (clk), .rst_n (rst_n),
    .line_one_i (line_one), .line_zero_i (line_zero),
    .pull_one_o (pull_one_o), .pull_zero_o (pull_zero_o),
    .byte_valid_o (byte_valid_o), .byte_data_o (byte_data_o),
    .byte_is_hdr_o (byte_is_hdr_o), .byte_idx_o (byte_idx_o),
    .wr_flag_o (wr_flag_o), .blk_size_o (blk_size_o),
    .addr_o (addr_o), .online_o (online_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor: R4 R5 R6 byte stream order, value, tag, index
  always @(negedge clk) begin
    if (rst_n && byte_valid_o) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R4 actual=%0h expected=none", byte_data_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (byte_data_o != e.d || byte_is_hdr_o != e.h || byte_idx_o != e.i) begin
          mon_fails++;
          $display("FAIL R6 actual=%0h/%0b/%0d expected=%0h/%0b/%0d",
                   byte_data_o, byte_is_hdr_o, byte_idx_o, e.d, e.h, e.i);
        end
      end
    end
  end

  task automatic wait_idle();
    while (!(line_one && line_zero)) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    int n;
    wait_idle();
    @(negedge clk);
    if (b) tb_one = 1'b1; else tb_zero = 1'b1;
    while (!(b ? pull_zero_o : pull_one_o)) @(negedge clk);
    if (b) chk(!pull_one_o, "R1", pull_one_o, 0);
    else   chk(!pull_zero_o, "R2", pull_zero_o, 0);
    repeat (5) @(negedge clk);
    chk(b ? pull_zero_o : pull_one_o, "R3", 0, 1);
    tb_one = 1'b0;
    tb_zero = 1'b0;
    n = 0;
    while ((pull_one_o || pull_zero_o) && n < 8) begin
      @(negedge clk);
      n++;
    end
    chk(!pull_one_o && !pull_zero_o, "R3", n, 8);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic h, input logic [6:0] i);
    exp_q.push_back('{d: d, h: h, i: i});
    for (int k = 7; k >= 0; k--) send_bit(d[k]);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_break(input logic skew);
    wait_idle();
    @(negedge clk);
    tb_one = 1'b1;
    if (skew) @(negedge clk);
    tb_zero = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!pull_one_o && !pull_zero_o, "R8", {pull_one_o, pull_zero_o}, 0);
    end
    tb_one = 1'b0;
    tb_zero = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!pull_one_o && !pull_zero_o, "R10", {pull_one_o, pull_zero_o}, 0);
    chk(!online_o, "R10", online_o, 0);
    chk(!byte_valid_o, "R10", byte_valid_o, 0);

    // full block, header 139 -> write, size 11 (R5, R7)
    send_byte(8'd139, 1'b1, 7'd0);
    chk(wr_flag_o == 1'b1, "R5", wr_flag_o, 1);
    chk(blk_size_o == 7'd11, "R5", blk_size_o, 11);
    chk(online_o, "R7", online_o, 1);
    send_byte(8'h00, 1'b1, 7'd1);
    send_byte(8'h00, 1'b1, 7'd2);
    chk(addr_o == 16'h0000, "R6", addr_o, 0);
    for (int k = 0; k < 8; k++) begin
      send_byte(8'h01 + 8'(k) * 8'h22, 1'b0, 7'(3 + k));
      if (k < 7) chk(online_o, "R7", online_o, 1);
    end
    chk(!online_o, "R7", online_o, 0);

    // second block with address, partial byte then break (R6, R8)
    send_byte(8'd139, 1'b1, 7'd0);
    send_byte(8'h12, 1'b1, 7'd1);
    send_byte(8'h34, 1'b1, 7'd2);
    chk(addr_o == 16'h1234, "R6", addr_o, 16'h1234);
    send_byte(8'hA5, 1'b0, 7'd3);
    send_byte(8'h5A, 1'b0, 7'd4);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_break(1'b0);
    chk(!online_o, "R8", online_o, 0);
    send_byte(8'h3C, 1'b0, 7'd5);
    chk(online_o, "R8", online_o, 1);
    send_byte(8'hC3, 1'b0, 7'd6);
    send_byte(8'h0F, 1'b0, 7'd7);
    send_break(1'b1);
    chk(!online_o, "R8", online_o, 0);
    send_byte(8'hF0, 1'b0, 7'd8);
    send_byte(8'h99, 1'b0, 7'd9);
    send_byte(8'h66, 1'b0, 7'd10);
    chk(!online_o, "R7", online_o, 0);

    // break with no open block, then a read header of size 5 (R9, R5)
    send_break(1'b0);
    chk(!online_o, "R9", online_o, 0);
    send_byte(8'h05, 1'b1, 7'd0);
    chk(wr_flag_o == 1'b0, "R5", wr_flag_o, 0);
    chk(blk_size_o == 7'd5, "R5", blk_size_o, 5);
    chk(online_o, "R9", online_o, 1);
    send_byte(8'hFF, 1'b1, 7'd1);
    send_byte(8'h80, 1'b1, 7'd2);
    chk(addr_o == 16'hFF80, "R6", addr_o, 16'hFF80);
    send_byte(8'h7E, 1'b0, 7'd3);
    send_byte(8'h81, 1'b0, 7'd4);
    chk(!online_o, "R7", online_o, 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule